// File: doc/BRIEF.md
# Single-Lane FEC Alignment Marker Mapper

This block sits on the transmit path between a four-lane 64b/66b PCS and a Reed-Solomon encoder that works on 10-bit symbols and serialises everything onto one FEC lane. The PCS stream carries one 66-bit alignment marker per PCS lane in each marker period. The mapper takes those markers out of the PCS stream and drops each 2-bit sync header. It packs the four 64-bit payloads, plus one pad bit, into a single 257-bit marker block.

The output is a stream of 257-bit blocks, paced by a slot tick. A full marker period holds 1024 RS(544,514) codewords. That is 1024 × 514 × 10 bits, which equals 20480 blocks of 257 bits, so each codeword spans 20 blocks. Slot 0 of the period carries the marker block. Every other slot carries a 257-bit data block taken from the upstream transcoder input. The block flags the first block of each codeword and the marker slot.

Output stays quiet after reset and after any loss of PCS lane alignment. It stays quiet until a complete marker set has arrived in lane order starting with lane 0. The period then restarts at slot 0.

Top module: `fec_am_mapper`

## Requirements
- R1: While reset is held and after its release, out_valid, out_sof and out_am are 0 until a period has been started (R3).
- R2: A captured marker contributes pcs_block[65:2] as its payload. In the marker block, lane n occupies out_block[64n+63:64n] for n = 0..3, and the pad bit sits at out_block[256].
- R3: A period starts only after markers for lanes 0, 1, 2 and 3 arrive in that order while lanes_locked is 1. A marker for any other lane during that collection sends the mapper back to waiting for lane 0.
- R4: The first tick after a period starts emits slot 0, which is the marker block, with out_am = 1 and out_sof = 1.
- R5: Every slot other than slot 0 emits dat_block unchanged, with out_am = 0.
- R6: out_sof is 1 on every slot whose index is a multiple of BLK_PER_CW (20), and 0 on all other slots.
- R7: out_am is 1 on exactly one slot per BLK_PER_CW × CW_PER_PERIOD (20480) slots, and the slot index then wraps to 0.
- R8: A cycle without slot_tick produces out_valid = 0 and does not advance the slot index.
- R9: When lanes_locked is 0, the next cycle has out_valid = 0. After lock returns, a new lane-ordered marker set is needed, and output resumes at slot 0.
- R10: Markers that arrive while the period runs replace the stored payload for their lane. The next slot 0 uses the replaced payloads.
- R11: Outputs are registered: the block for a tick in cycle t appears after the clock edge that ends cycle t.
- R12: A block flagged as a marker is captured only when its sync header pcs_block[1:0] equals 2'b10. A flagged block with any other header is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lanes_locked | input | 1 | PCS lane alignment achieved |
| pcs_valid | input | 1 | A 66-bit PCS block is present |
| pcs_is_am | input | 1 | The present PCS block is an alignment marker |
| pcs_lane | input | 2 | PCS lane of the present block |
| pcs_block | input | 66 | PCS block, sync header in bits 1:0 |
| slot_tick | input | 1 | One 257-bit output slot is due this cycle |
| dat_block | input | 257 | Data block for the current slot |
| out_valid | output | 1 | A 257-bit block is presented |
| out_sof | output | 1 | First block of an RS codeword |
| out_am | output | 1 | Block is the marker block (slot 0) |
| out_block | output | 257 | Output 257-bit block |

## Verification
The hardest situations to reach are the second slot 0 of a running period, which must carry payloads replaced mid-period, and a lock loss that lands part-way through a period. Both lie more than ten thousand slots past the start. The stimulus gets there with long runs of randomly gapped ticks and random data, and injects a fresh marker set and a lock drop at fixed cycle counts. Directed sequences before the run cover collection in the wrong lane order and a marker with a wrong sync header.

// File: rtl/fam_pkg.sv
`timescale 1ns/1ps
package fam_pkg;
    localparam int NUM_LANES = 4;
    localparam int LANE_W    = $clog2(NUM_LANES);
    localparam int PCS_W     = 66;
    localparam int PAY_W     = 64;
    localparam int MK_W      = NUM_LANES * PAY_W;
    localparam int FEC_W     = MK_W + 1;
    localparam logic [1:0] CTRL_HDR = 2'b10;

    typedef enum logic [1:0] {
        CAP_WAIT,
        CAP_COLLECT,
        CAP_RUN
    } cap_state_e;
endpackage

// File: rtl/fam_marker_capture.sv
`timescale 1ns/1ps
module fam_marker_capture
    import fam_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 lanes_locked,
    input  logic                 pcs_valid,
    input  logic                 pcs_is_am,
    input  logic [LANE_W-1:0]    pcs_lane,
    input  logic [PCS_W-1:0]     pcs_block,
    output logic                 running,
    output logic [MK_W-1:0]      marker_flat
);
    typedef struct packed {
        cap_state_e                          st;
        logic [LANE_W-1:0]                   want;
        logic [NUM_LANES-1:0][PAY_W-1:0]     pay;
    } cap_t;

    cap_t cap_d, cap_q;
    logic hit;

    always_comb begin
        cap_d = cap_q;
        hit   = pcs_valid && pcs_is_am && (pcs_block[1:0] == CTRL_HDR);
        if (!lanes_locked) begin
            cap_d.st = CAP_WAIT;
        end else begin
            unique case (cap_q.st)
                CAP_WAIT: begin
                    if (hit && pcs_lane == '0) begin
                        cap_d.pay[0] = pcs_block[PCS_W-1:2];
                        cap_d.want   = LANE_W'(1);
                        cap_d.st     = CAP_COLLECT;
                    end
                end
                CAP_COLLECT: begin
                    if (hit) begin
                        if (pcs_lane == cap_q.want) begin
                            cap_d.pay[pcs_lane] = pcs_block[PCS_W-1:2];
                            if (cap_q.want == LANE_W'(NUM_LANES-1))
                                cap_d.st = CAP_RUN;
                            else
                                cap_d.want = cap_q.want + LANE_W'(1);
                        end else begin
                            cap_d.st = CAP_WAIT;
                        end
                    end
                end
                CAP_RUN: begin
                    if (hit)
                        cap_d.pay[pcs_lane] = pcs_block[PCS_W-1:2];
                end
                default: cap_d.st = CAP_WAIT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q.st   <= CAP_WAIT;
            cap_q.want <= '0;
            cap_q.pay  <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign running     = (cap_q.st == CAP_RUN);
    assign marker_flat = cap_q.pay;

    AST_RUN_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> $past(lanes_locked)); // R9
    AST_COLLECT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_q.st == CAP_WAIT && cap_d.st == CAP_COLLECT) |-> (pcs_lane == '0)); // R3
endmodule

// File: rtl/fam_slot_counter.sv
`timescale 1ns/1ps
module fam_slot_counter #(
    parameter int BLK_PER_CW    = 20,
    parameter int CW_PER_PERIOD = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic cw_first,
    output logic period_first
);
    localparam int BLK_W = $clog2(BLK_PER_CW);
    localparam int CW_W  = $clog2(CW_PER_PERIOD);

    typedef struct packed {
        logic [BLK_W-1:0] blk;
        logic [CW_W-1:0]  cw;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!run) begin
            cnt_d = '0;
        end else if (tick) begin
            if (cnt_q.blk == BLK_W'(BLK_PER_CW-1)) begin
                cnt_d.blk = '0;
                if (cnt_q.cw == CW_W'(CW_PER_PERIOD-1))
                    cnt_d.cw = '0;
                else
                    cnt_d.cw = cnt_q.cw + CW_W'(1);
            end else begin
                cnt_d.blk = cnt_q.blk + BLK_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cw_first     = (cnt_q.blk == '0);
    assign period_first = cw_first && (cnt_q.cw == '0);

    AST_BLK_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q.blk < BLK_W'(BLK_PER_CW)); // R6
    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick) |=> ($stable(cnt_q.blk) && $stable(cnt_q.cw))); // R8
endmodule

// File: rtl/fam_pad_source.sv
`timescale 1ns/1ps
module fam_pad_source #(
    parameter int LFSR_W = 15
) (
    input  logic clk,
    input  logic rst_n,
    output logic pad_bit
);
    logic [LFSR_W-1:0] lfsr_d, lfsr_q;

    always_comb begin
        lfsr_d = {lfsr_q[LFSR_W-2:0], lfsr_q[LFSR_W-1] ^ lfsr_q[LFSR_W-2]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lfsr_q <= LFSR_W'(1);
        else        lfsr_q <= lfsr_d;
    end

    assign pad_bit = lfsr_q[LFSR_W-1];

    AST_LFSR_ALIVE: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != '0); // R2
endmodule

// File: rtl/fec_am_mapper.sv
`timescale 1ns/1ps
module fec_am_mapper
    import fam_pkg::*;
#(
    parameter int BLK_PER_CW    = 20,
    parameter int CW_PER_PERIOD = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lanes_locked,
    input  logic              pcs_valid,
    input  logic              pcs_is_am,
    input  logic [1:0]        pcs_lane,
    input  logic [65:0]       pcs_block,
    input  logic              slot_tick,
    input  logic [256:0]      dat_block,
    output logic              out_valid,
    output logic              out_sof,
    output logic              out_am,
    output logic [256:0]      out_block
);
    typedef struct packed {
        logic              valid;
        logic              sof;
        logic              am;
        logic [FEC_W-1:0]  block;
    } out_t;

    out_t out_d, out_q;

    logic              running;
    logic [MK_W-1:0]   marker_flat;
    logic              cw_first;
    logic              period_first;
    logic              pad_bit;
    logic [FEC_W-1:0]  am_block;

    fam_marker_capture u_cap (
        .clk          (clk),
        .rst_n        (rst_n),
        .lanes_locked (lanes_locked),
        .pcs_valid    (pcs_valid),
        .pcs_is_am    (pcs_is_am),
        .pcs_lane     (pcs_lane),
        .pcs_block    (pcs_block),
        .running      (running),
        .marker_flat  (marker_flat)
    );

    fam_slot_counter #(
        .BLK_PER_CW    (BLK_PER_CW),
        .CW_PER_PERIOD (CW_PER_PERIOD)
    ) u_cnt (
        .clk          (clk),
        .rst_n        (rst_n),
        .run          (running),
        .tick         (slot_tick),
        .cw_first     (cw_first),
        .period_first (period_first)
    );

    fam_pad_source u_pad (
        .clk     (clk),
        .rst_n   (rst_n),
        .pad_bit (pad_bit)
    );

    for (genvar ln = 0; ln < NUM_LANES; ln++) begin : g_lane_pack
        assign am_block[ln*PAY_W +: PAY_W] = marker_flat[ln*PAY_W +: PAY_W];
    end
    assign am_block[FEC_W-1] = pad_bit;

    always_comb begin
        out_d       = '0;
        out_d.valid = slot_tick && running && lanes_locked;
        out_d.sof   = out_d.valid && cw_first;
        out_d.am    = out_d.valid && period_first;
        out_d.block = out_d.am ? am_block : dat_block;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign out_valid = out_q.valid;
    assign out_sof   = out_q.sof;
    assign out_am    = out_q.am;
    assign out_block = out_q.block;

    AST_AM_HAS_SOF: assert property (@(posedge clk) disable iff (!rst_n)
        out_am |-> out_sof); // R7
    AST_SOF_HAS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |-> out_valid); // R6
    AST_LOCK_LOSS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !lanes_locked |=> !out_valid); // R9
    AST_VALID_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(slot_tick)); // R8
    AST_DATA_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_am) |-> (out_block == $past(dat_block))); // R5
endmodule

// File: tb/tb_fec_am_mapper.sv
`timescale 1ns/1ps
module tb_fec_am_mapper;
    localparam int SLOTS = 20 * 1024;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         lanes_locked = 1'b0;
    logic         pcs_valid = 1'b0;
    logic         pcs_is_am = 1'b0;
    logic [1:0]   pcs_lane = '0;
    logic [65:0]  pcs_block = '0;
    logic         slot_tick = 1'b0;
    logic [256:0] dat_block = '0;
    logic         out_valid, out_sof, out_am;
    logic [256:0] out_block;

    int total = 0;
    int bad = 0;

    // specification model
    int          m_st = 0;
    int          m_want = 0;
    int          m_slot = 0;
    logic [63:0] m_pay [4];
    bit          fresh_set = 1'b0;

    always #2 clk = ~clk;

    fec_am_mapper dut (
        .clk(clk), .rst_n(rst_n), .lanes_locked(lanes_locked),
        .pcs_valid(pcs_valid), .pcs_is_am(pcs_is_am), .pcs_lane(pcs_lane),
        .pcs_block(pcs_block), .slot_tick(slot_tick), .dat_block(dat_block),
        .out_valid(out_valid), .out_sof(out_sof), .out_am(out_am),
        .out_block(out_block)
    );

    function automatic logic [255:0] exp_marker();
        return {m_pay[3], m_pay[2], m_pay[1], m_pay[0]};
    endfunction

    function automatic logic [256:0] rand_blk();
        logic [31:0] r;
        r = $urandom();
        return {r[0], $urandom(), $urandom(), $urandom(), $urandom(),
                $urandom(), $urandom(), $urandom(), $urandom()};
    endfunction

    task automatic chk(input string tag, input logic [256:0] act, input logic [256:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // one clock: predict, advance model, then compare after the edge
    task automatic cyc();
        logic e_valid, e_sof, e_am, hit;
        logic [256:0] e_blk;
        string tag;
        e_valid = slot_tick && lanes_locked && (m_st == 2);
        e_sof   = e_valid && (m_slot % 20 == 0);
        e_am    = e_valid && (m_slot == 0);
        e_blk   = dat_block;
        if (e_am) tag = fresh_set ? "R10 R2 R4 R7" : "R2 R4 R7";
        else if (e_valid) tag = "R5 R6 R11";
        else if (!lanes_locked) tag = "R9";
        else if (!slot_tick) tag = "R8";
        else tag = "R1 R3 R12";
        if (e_am) e_blk[255:0] = exp_marker();
        hit = pcs_valid && pcs_is_am && (pcs_block[1:0] == 2'b10);
        if (m_st == 2) begin
            if (slot_tick) m_slot = (m_slot + 1) % SLOTS;
        end else begin
            m_slot = 0;
        end
        if (!lanes_locked) m_st = 0;
        else case (m_st)
            0: if (hit && pcs_lane == 2'd0) begin
                   m_pay[0] = pcs_block[65:2]; m_want = 1; m_st = 1;
               end
            1: if (hit) begin
                   if (int'(pcs_lane) == m_want) begin
                       m_pay[pcs_lane] = pcs_block[65:2];
                       if (m_want == 3) m_st = 2; else m_want++;
                   end else m_st = 0;
               end
            default: if (hit) m_pay[pcs_lane] = pcs_block[65:2];
        endcase
        @(posedge clk);
        @(negedge clk);
        chk({tag, " out_valid"}, 257'(out_valid), 257'(e_valid));
        if (e_valid) begin
            chk({tag, " out_sof"}, 257'(out_sof), 257'(e_sof));
            chk({tag, " out_am"}, 257'(out_am), 257'(e_am));
            if (e_am) chk({tag, " marker"}, 257'(out_block[255:0]), 257'(e_blk[255:0]));
            else      chk({tag, " data"}, out_block, e_blk);
            if (e_am && fresh_set) fresh_set = 1'b0;
        end
        pcs_valid = 1'b0;
        pcs_is_am = 1'b0;
    endtask

    task automatic send_mk(input int lane, input logic [63:0] pay, input logic [1:0] hdr);
        pcs_valid = 1'b1;
        pcs_is_am = 1'b1;
        pcs_lane  = 2'(lane);
        pcs_block = {pay, hdr};
        slot_tick = 1'b0;
        cyc();
    endtask

    task automatic idle_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            slot_tick = 1'b1;
            dat_block = rand_blk();
            cyc();
        end
        slot_tick = 1'b0;
    endtask

    task automatic send_set(input logic [63:0] base);
        for (int ln = 0; ln < 4; ln++) send_mk(ln, base ^ {32'(ln), 32'hA5A5_0000 + 32'(ln)}, 2'b10);
    endtask

    task automatic rand_run(input int n);
        for (int i = 0; i < n; i++) begin
            slot_tick = ($urandom() % 4) != 0;
            dat_block = rand_blk();
            pcs_valid = ($urandom() % 2) == 0;
            pcs_is_am = 1'b0;
            pcs_lane  = 2'($urandom());
            pcs_block = {$urandom(), $urandom(), 2'b01};
            cyc();
        end
    endtask

    initial begin
        #780000;
        bad++;
        total++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < 4; i++) m_pay[i] = '0;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 reset valid", 257'(out_valid), 257'(0));
        chk("R1 reset sof", 257'(out_sof), 257'(0));
        chk("R1 reset am", 257'(out_am), 257'(0));
        rst_n = 1'b1;
        // R1/R9: ticks before lock give no output
        idle_ticks(5);
        lanes_locked = 1'b1;
        idle_ticks(5);
        // R3: wrong lane order aborts collection
        send_mk(0, 64'h1111, 2'b10);
        send_mk(2, 64'h2222, 2'b10);
        send_mk(3, 64'h3333, 2'b10);
        idle_ticks(4);
        // R12: marker with data header is ignored, so lanes 1..3 cannot start a period
        send_mk(0, 64'h4444, 2'b01);
        send_mk(1, 64'h5555, 2'b10);
        send_mk(2, 64'h6666, 2'b10);
        send_mk(3, 64'h7777, 2'b10);
        idle_ticks(4);
        // R3/R4: good sequence starts the period
        send_set(64'hDEAD_BEEF_0123_4567);
        idle_ticks(45);
        rand_run(15000);
        // R10: fresh marker set in mid period
        send_set(64'h0F1E_2D3C_4B5A_6978);
        fresh_set = 1'b1;
        rand_run(30000);
        // R9: lock loss mid period, then restart
        lanes_locked = 1'b0;
        idle_ticks(3);
        lanes_locked = 1'b1;
        idle_ticks(3);
        send_set(64'h8888_7777_6666_5555);
        idle_ticks(25);
        rand_run(5000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule